// File: doc/BRIEF.md
# I2C Serial Clock Generator with Clock Stretching

This block produces the serial clock for an I2C bus master. The clock rate comes from one of two sources, chosen by a 3-bit rate code. Codes 0 to 6 divide the local bus clock by a fixed ratio. Code 7 hands the timing to an external rate pulse. That pulse is asynchronous, so it is synchronized before use, and each of its rising edges advances the phase counter by one.

The line is driven open-drain. While `sclOe` is high the pad pulls SCL low; otherwise SCL is released and the pull-up takes it high. The block reads SCL back after every release. If a slave holds the line low, the high phase does not begin until the synchronized readback shows the line high. A slave can therefore stretch the clock for any length of time.

Two single-cycle strobes mark the edges for a neighbouring data shifter: `sclFall` marks where SCL is driven low, and `sclRise` marks where SCL is seen high. Start and stop sequencing and byte shifting belong to other blocks.

Top module: `i2c_scl_gen`

## Requirements
- R1: For rate codes 0,1,2,3,4,5,6 the full SCL period is 256,224,192,160,960,120,60 clock cycles. The low phase lasts half of that period. The high phase lasts the same number of cycles, counted from the `sclRise` cycle.
- R2: `sclOe`=1 pulls SCL low and `sclOe`=0 releases it. The block never drives the line high. When each low phase ends, `sclOe` returns to 0.
- R3: With rate code 3'b111 the phase timing comes from the external pulse. Each low phase and each high phase lasts 4 synchronized rising edges of `bclkIn`.
- R4: `bclkIn` passes through a two-flop synchronizer. Each rising edge yields exactly one count, however long the pulse stays high.
- R5: `sclIn` passes through a two-flop synchronizer. After a release, the high phase starts only once the synchronized line reads high. A low hold of any length only delays it and causes no error.
- R6: `sclRise` is a one-cycle strobe. It is issued with `sclOe`=0 in the first cycle after the synchronized readback is seen high following a release.
- R7: `sclFall` is a one-cycle strobe. It is issued in the first cycle in which `sclOe` goes to 1.
- R8: A new rate code is latched only when a low phase starts. A change made in the middle of a phase leaves that phase and the following high phase unchanged.
- R9: While `rst`=1, or in the cycle after `enable`=0 is sampled, `sclOe`, `sclRise` and `sclFall` are 0. No further edges are produced until `enable` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rst | input | 1 | Active-high reset, asserted at power-up |
| enable | input | 1 | Runs the generator when 1 |
| rateCode | input | 3 | Rate selection; 3'b111 selects the external pulse |
| bclkIn | input | 1 | Asynchronous external rate pulse |
| sclIn | input | 1 | Readback of the SCL line |
| sclOe | output | 1 | Pulls SCL low when 1 |
| sclRise | output | 1 | One-cycle strobe: SCL seen high |
| sclFall | output | 1 | One-cycle strobe: SCL driven low |

## Verification
The bound checker watches the strobes on every cycle. It confirms that each strobe lasts a single cycle, that `sclFall` coincides with the start of the low drive, and that `sclRise` occurs only with the line released and only when the line was high three samples earlier. It also confirms that a deasserted enable releases the line on the next cycle. Phase lengths cannot be shown by cycle-local properties. That covers the per-code dividers, the count of external pulses, the deferred rate change and a long slave hold. These rely on the bench scenarios and its cycle model, which track whole phases across hundreds of cycles.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  localparam logic [2:0] RATE_EXT = 3'b111;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_WAITHI,
    ST_HIGH
  } sclState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic rateLoad;
  } ctrlStrb_t;

  // half of the full SCL period in bus clock cycles, per rate code
  function automatic int unsigned busHalf(input logic [2:0] code);
    case (code)
      3'd0:    busHalf = 128;
      3'd1:    busHalf = 112;
      3'd2:    busHalf = 96;
      3'd3:    busHalf = 80;
      3'd4:    busHalf = 480;
      3'd5:    busHalf = 60;
      3'd6:    busHalf = 30;
      default: busHalf = 1;
    endcase
  endfunction

endpackage

// File: rtl/sclgen_dp.sv
module sclgen_dp
  import sclgen_pkg::*;
#(
  parameter int CntW      = 9,
  parameter int ExtHalf   = 4,
  parameter int SyncDepth = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic [2:0] rateCode,
  input  logic      bclkIn,
  input  logic      sclIn,
  input  ctrlStrb_t strb,
  output logic      tick,
  output logic      cntLast,
  output logic      sclHigh
);

  logic [SyncDepth-1:0] sclSync;
  logic [SyncDepth:0]   bclkSync;
  logic [2:0]           rateQ;
  logic [CntW-1:0]      cnt;
  logic [CntW-1:0]      halfLim;
  logic                 extMode;
  logic                 bclkEdge;

  // synchronizer chains
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sclSync  <= '0;
      bclkSync <= '0;
    end else begin
      sclSync  <= {sclSync[SyncDepth-2:0], sclIn};
      bclkSync <= {bclkSync[SyncDepth-1:0], bclkIn};
    end
  end

  assign sclHigh  = sclSync[SyncDepth-1];
  assign bclkEdge = bclkSync[SyncDepth-1] & ~bclkSync[SyncDepth];

  // rate code captured only at the start of a low phase
  always_ff @(posedge clk or posedge rst) begin
    if (rst)               rateQ <= '0;
    else if (strb.rateLoad) rateQ <= rateCode;
  end

  assign extMode = (rateQ == RATE_EXT);

  always_comb begin
    if (extMode) halfLim = CntW'(ExtHalf);
    else         halfLim = CntW'(busHalf(rateQ));
  end

  assign tick    = extMode ? bclkEdge : 1'b1;
  assign cntLast = (cnt == halfLim - 1'b1);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)              cnt <= '0;
    else if (strb.cntClr) cnt <= '0;
    else if (strb.cntInc) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/sclgen_ctrl.sv
module sclgen_ctrl
  import sclgen_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      enable,
  input  logic      tick,
  input  logic      cntLast,
  input  logic      sclHigh,
  output ctrlStrb_t strb,
  output logic      sclOe,
  output logic      sclRise,
  output logic      sclFall
);

  sclState_e state, nextState;
  logic riseD, fallD;
  logic riseQ, fallQ;

  always_comb begin
    nextState = state;
    strb      = '0;
    riseD     = 1'b0;
    fallD     = 1'b0;
    if (!enable) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          nextState     = ST_LOW;
          strb.rateLoad = 1'b1;
          strb.cntClr   = 1'b1;
          fallD         = 1'b1;
        end
        ST_LOW: begin
          if (tick) begin
            if (cntLast) begin
              nextState   = ST_WAITHI;
              strb.cntClr = 1'b1;
            end else begin
              strb.cntInc = 1'b1;
            end
          end
        end
        ST_WAITHI: begin
          if (sclHigh) begin
            nextState   = ST_HIGH;
            strb.cntClr = 1'b1;
            riseD       = 1'b1;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            if (cntLast) begin
              nextState     = ST_LOW;
              strb.rateLoad = 1'b1;
              strb.cntClr   = 1'b1;
              fallD         = 1'b1;
            end else begin
              strb.cntInc = 1'b1;
            end
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state <= ST_IDLE;
      riseQ <= 1'b0;
      fallQ <= 1'b0;
    end else begin
      state <= nextState;
      riseQ <= riseD;
      fallQ <= fallD;
    end
  end

  assign sclOe   = (state == ST_LOW);
  assign sclRise = riseQ;
  assign sclFall = fallQ;

endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
  import sclgen_pkg::*;
#(
  parameter int CntW      = 9,
  parameter int ExtHalf   = 4,
  parameter int SyncDepth = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic [2:0] rateCode,
  input  logic       bclkIn,
  input  logic       sclIn,
  output logic       sclOe,
  output logic       sclRise,
  output logic       sclFall
);

  ctrlStrb_t strb;
  logic tick, cntLast, sclHigh;

  sclgen_dp #(
    .CntW     (CntW),
    .ExtHalf  (ExtHalf),
    .SyncDepth(SyncDepth)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .rateCode(rateCode),
    .bclkIn  (bclkIn),
    .sclIn   (sclIn),
    .strb    (strb),
    .tick    (tick),
    .cntLast (cntLast),
    .sclHigh (sclHigh)
  );

  sclgen_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .enable (enable),
    .tick   (tick),
    .cntLast(cntLast),
    .sclHigh(sclHigh),
    .strb   (strb),
    .sclOe  (sclOe),
    .sclRise(sclRise),
    .sclFall(sclFall)
  );

endmodule

// File: rtl/sclgen_chk.sv
module sclgen_chk (
  input logic       clk,
  input logic       rst,
  input logic       enable,
  input logic [2:0] rateCode,
  input logic       bclkIn,
  input logic       sclIn,
  input logic       sclOe,
  input logic       sclRise,
  input logic       sclFall
);

  // R7
  fall_drives_chk: assert property (@(posedge clk) disable iff (rst)
    sclFall |-> sclOe);

  // R7
  drive_start_strobed_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sclOe) |-> sclFall);

  // R7
  fall_single_chk: assert property (@(posedge clk) disable iff (rst)
    sclFall |=> !sclFall);

  // R6
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    sclRise |=> !sclRise);

  // R6
  rise_released_chk: assert property (@(posedge clk) disable iff (rst)
    sclRise |-> !sclOe);

  // R5
  release_no_instant_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sclOe) |-> !sclRise);

  // R5
  rise_after_line_high_chk: assert property (@(posedge clk) disable iff (rst)
    sclRise |-> $past(sclIn, 3));

  // R9
  disable_releases_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!sclOe && !sclFall && !sclRise));

endmodule

bind i2c_scl_gen sclgen_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .enable  (enable),
  .rateCode(rateCode),
  .bclkIn  (bclkIn),
  .sclIn   (sclIn),
  .sclOe   (sclOe),
  .sclRise (sclRise),
  .sclFall (sclFall)
);

// File: tb/tb_i2c_scl_gen.sv
`timescale 1ns/1ps
module tb_i2c_scl_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic [2:0] rateCode = 3'd6;
  logic       bclkIn = 1'b0;
  logic       holdLow = 1'b0;
  logic       sclIn;
  logic       sclOe, sclRise, sclFall;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit bclkRun = 0;

  always #2.5 clk = ~clk;

  assign sclIn = !(sclOe || holdLow);

  i2c_scl_gen dut (
    .clk(clk), .rst(rst), .enable(enable), .rateCode(rateCode),
    .bclkIn(bclkIn), .sclIn(sclIn),
    .sclOe(sclOe), .sclRise(sclRise), .sclFall(sclFall)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  function automatic int halfCycles(input int code);
    int t[7] = '{128, 112, 96, 80, 480, 60, 30};
    if (code == 7) return 4;
    return t[code];
  endfunction

  int mPhase, mCnt, mRate;      // phase: 0 idle, 1 low, 2 wait, 3 high
  bit mRise, mFall;
  bit s1, s2, b1, b2, b3;

  always @(posedge clk or posedge rst) begin
    if (rst) begin
      mPhase = 0; mCnt = 0; mRate = 0; mRise = 0; mFall = 0;
      s1 = 0; s2 = 0; b1 = 0; b2 = 0; b3 = 0;
    end else begin
      bit line, tk, nr, nf;
      int h;
      line = (mPhase != 1) && !holdLow;
      tk   = (mRate == 7) ? (b2 && !b3) : 1'b1;
      h    = halfCycles(mRate);
      nr = 0; nf = 0;
      if (!enable) mPhase = 0;
      else if (mPhase == 0) begin
        mPhase = 1; mRate = rateCode; mCnt = 0; nf = 1;
      end else if (mPhase == 1) begin
        if (tk) begin
          if (mCnt == h - 1) begin mPhase = 2; mCnt = 0; end
          else mCnt++;
        end
      end else if (mPhase == 2) begin
        if (s2) begin mPhase = 3; mCnt = 0; nr = 1; end
      end else begin
        if (tk) begin
          if (mCnt == h - 1) begin
            mPhase = 1; mRate = rateCode; mCnt = 0; nf = 1;
          end else mCnt++;
        end
      end
      mRise = nr; mFall = nf;
      s2 = s1; s1 = line;
      b3 = b2; b2 = b1; b1 = bclkIn;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (!finished) begin
      check(sclOe == (mPhase == 1), "R2", "sclOe vs model", sclOe, mPhase == 1);
      check(sclRise == mRise, "R6", "sclRise vs model", sclRise, mRise);
      check(sclFall == mFall, "R7", "sclFall vs model", sclFall, mFall);
    end
  end

  // ---------------- phase-length monitor ----------------
  int lowQ[$];
  int highQ[$];
  int lowRun, highRun, riseCount, fallCount;
  bit inHigh, prevOe;

  always @(negedge clk) begin
    if (rst) begin
      prevOe = 0; inHigh = 0;
    end else begin
      if (sclFall) begin
        fallCount++; lowRun = 0;
        if (inHigh) begin highQ.push_back(highRun); inHigh = 0; end
      end
      if (sclOe) lowRun++;
      if (prevOe && !sclOe) lowQ.push_back(lowRun);
      if (sclRise) begin riseCount++; inHigh = 1; highRun = 0; end
      if (inHigh && !sclOe) highRun++;
      prevOe = sclOe;
    end
  end

  // external rate pulse: period 10 cycles, high for 6
  int bPh = 0;
  always @(posedge clk) begin
    #1;
    if (bclkRun) begin
      bPh = (bPh + 1) % 10;
      bclkIn = (bPh < 6);
    end else bclkIn = 1'b0;
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clearQ();
    lowQ.delete();
    highQ.delete();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int r0, f0;
    // R9: reset holds the line released even with enable set
    enable = 1;
    cycles(5);
    @(negedge clk);
    check(!sclOe && !sclRise && !sclFall, "R9", "outputs in reset", sclOe, 0);
    @(posedge clk); #1;
    rst = 0;

    // R1 / R5 / R6: code 6, half 30
    cycles(20);
    clearQ();
    cycles(300);
    check(lowQ.size() >= 3, "R1", "low phases seen, code 6", lowQ.size(), 3);
    foreach (lowQ[i]) check(lowQ[i] == 30, "R1", "low length code 6", lowQ[i], 30);
    foreach (highQ[i]) check(highQ[i] == 30, "R1", "high length code 6", highQ[i], 30);

    // R1: code 4, half 480
    rateCode = 3'd4;
    cycles(3000);
    check(lowQ[$] == 480, "R1", "low length code 4", lowQ[$], 480);
    check(highQ[$] == 480, "R1", "high length code 4", highQ[$], 480);

    // R8: change rate mid-phase
    rateCode = 3'd0;
    do @(negedge clk); while (!sclFall);
    @(posedge clk); #1;
    clearQ();
    cycles(5);
    rateCode = 3'd6;
    cycles(400);
    check(lowQ.size() >= 2, "R8", "low phases after change", lowQ.size(), 2);
    check(lowQ[0] == 128, "R8", "current low keeps old rate", lowQ[0], 128);
    check(highQ[0] == 128, "R8", "following high keeps old rate", highQ[0], 128);
    check(lowQ[1] == 30, "R8", "next low uses new rate", lowQ[1], 30);

    // R5: slave stretches the clock for a long time
    do @(negedge clk); while (!sclOe);
    @(posedge clk); #1;
    holdLow = 1;
    clearQ();
    r0 = riseCount;
    cycles(400);
    check(riseCount == r0, "R5", "no rise while held low", riseCount, r0);
    @(negedge clk);
    check(!sclOe, "R2", "line released after low phase", sclOe, 0);
    @(posedge clk); #1;
    holdLow = 0;
    cycles(100);
    check(riseCount > r0, "R6", "rise after hold ends", riseCount, r0 + 1);
    check(highQ.size() > 0 && highQ[0] == 30, "R5", "full high after stretch",
          highQ.size() > 0 ? highQ[0] : -1, 30);

    // R3 / R4: external pulse mode with wide pulses
    bclkRun = 1;
    rateCode = 3'b111;
    cycles(300);
    clearQ();
    cycles(800);
    check(lowQ.size() >= 3, "R3", "low phases in pulse mode", lowQ.size(), 3);
    foreach (lowQ[i]) check(lowQ[i] >= 30 && lowQ[i] <= 41, "R4",
                            "low length 4 pulses", lowQ[i], 40);
    foreach (highQ[i]) check(highQ[i] >= 30 && highQ[i] <= 41, "R3",
                             "high length 4 pulses", highQ[i], 40);

    // R9: disable releases the line and stops edges
    enable = 0;
    cycles(2);
    @(negedge clk);
    check(!sclOe, "R9", "released after disable", sclOe, 0);
    f0 = fallCount;
    cycles(200);
    check(fallCount == f0, "R9", "no edges while disabled", fallCount, f0);

    summary();
  end

endmodule